// File: doc/BRIEF.md
# Speculative read cancellation tracker

This block follows every speculatively issued memory read from the moment it is queued until its data comes back. Each read carries a transaction tag, and the tracker holds a small state for each tag. A read can be withdrawn until the arbiter commits it to issue. Once the read is committed it can no longer be withdrawn, so a cancel that arrives after that point only marks the read's data to be thrown away when it returns.

The scheduler reports enqueues, commits and data returns. The coherency and request logic send cancels, each with one of four reasons. In return the tracker tells the scheduler which pending reads to drop, which enqueued reads fell outside every interleave range and must never issue, and whether each returning data beat should be delivered or discarded. All outputs are registered and appear one cycle after the input that causes them.

Top module: `spec_rd_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, every tag is idle (state 2'b00). `drop_o`, `miss_drop_o`, `deliver_o`, `discard_o` and `err_o` are all 0.
- R2: An enqueue with `enq_range_hit_i`=1 moves an idle tag to pending (state 2'b01). The enqueue itself raises no output.
- R3: A cancel aimed at a pending tag, with no commit for that tag in the same cycle, raises `drop_o` for one cycle on the next cycle with `drop_tag_o` equal to the tag. The tag then returns to idle.
- R4: A cancel aimed at a committed tag (state 2'b10) raises no `drop_o`. It moves the tag to cancelled-after-commit (state 2'b11), and the next data return for that tag raises `discard_o`, not `deliver_o`.
- R5: When a commit and a cancel for the same pending tag arrive in the same cycle, the commit wins. No drop is raised, and the tag's returning data is discarded.
- R6: A cancel aimed at an idle tag has no effect on any tag or on `drop_o`. It sets `err_o`, which stays 1 until reset.
- R7: A data return for a committed tag raises `deliver_o` one cycle later with `ret_tag_o` equal to the tag, and the tag returns to idle. `deliver_o` and `discard_o` are never 1 together.
- R8: An enqueue with `enq_range_hit_i`=0 raises `miss_drop_o` one cycle later with `miss_tag_o` equal to the tag. The tag stays idle.
- R9: A data return and a cancel for the same committed tag in the same cycle count as a late cancel. `discard_o` is raised and the tag returns to idle.
- R10: A data return for an idle or pending tag is ignored. No deliver or discard is raised, and a pending tag stays cancellable.
- R11: The cancel reason is copied to `drop_reason_o`. The codes are 0 implicit write-back response, 1 explicit speculative-read cancel request, 2 coherency conflict and 3 transaction retry.
- R12: An enqueue, a commit, a cancel and a return that name different tags in the same cycle each take effect independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | A speculative read is enqueued |
| enq_tag_i | input | TAG_W | Tag of the enqueued read |
| enq_range_hit_i | input | 1 | The read's address falls in an interleave range |
| commit_valid_i | input | 1 | The arbiter commits a read to issue |
| commit_tag_i | input | TAG_W | Tag of the committed read |
| cancel_valid_i | input | 1 | A cancel request arrives |
| cancel_tag_i | input | TAG_W | Tag to cancel |
| cancel_reason_i | input | 2 | Cancel reason code |
| ret_valid_i | input | 1 | Read data returns |
| ret_tag_i | input | TAG_W | Tag of the returning data |
| drop_o | output | 1 | Scheduler must drop a pending read |
| drop_tag_o | output | TAG_W | Tag to drop |
| drop_reason_o | output | 2 | Reason for the drop |
| miss_drop_o | output | 1 | An enqueued read missed every range |
| miss_tag_o | output | TAG_W | Tag of the missed read |
| deliver_o | output | 1 | Returned data is to be delivered |
| discard_o | output | 1 | Returned data is to be thrown away |
| ret_tag_o | output | TAG_W | Tag of the deliver or discard decision |
| err_o | output | 1 | Sticky: a cancel hit an idle tag |

## Verification
The assertions assume that the scheduler obeys the tag protocol. A tag is enqueued only while it is idle, a commit names only a pending tag, and within one cycle the enqueue names a tag that no other operation uses. Only a commit, a cancel and a return may share a tag. The directed tasks draw a fresh tag for each scenario and walk it through a legal order. The cycles that put several operations on one tag are exactly the pairs that R5, R9 and R12 allow. The only protocol violation the stimulus makes on purpose is a cancel aimed at an idle tag, which the design is required to tolerate.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_COMM = 2'b10,
    ST_LATE = 2'b11
  } tag_state_e;

  typedef enum logic [1:0] {
    RSN_IMPL_WB  = 2'd0,
    RSN_EXPLICIT = 2'd1,
    RSN_COHER    = 2'd2,
    RSN_RETRY    = 2'd3
  } cancel_reason_e;
endpackage

// File: rtl/srt_onehot.sv
module srt_onehot #(
  parameter int N     = 32,
  parameter int TAG_W = $clog2(N)
) (
  input  logic             valid_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [N-1:0]     hot_o
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hot_o[i] = valid_i && (tag_i == TAG_W'(i));
  end
endmodule

// File: rtl/srt_state_mux.sv
module srt_state_mux
  import srt_pkg::*;
#(
  parameter int N     = 32,
  parameter int TAG_W = $clog2(N)
) (
  input  tag_state_e       st_i [N],
  input  logic [TAG_W-1:0] sel_i,
  output tag_state_e       st_o
);
  always_comb begin
    st_o = ST_IDLE;
    for (int i = 0; i < N; i++) begin
      if (sel_i == TAG_W'(i)) st_o = st_i[i];
    end
  end
endmodule

// File: rtl/srt_entry.sv
module srt_entry
  import srt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enq_i,
  input  logic       commit_i,
  input  logic       cancel_i,
  input  logic       ret_i,
  output tag_state_e state_o
);
  tag_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE: if (enq_i) state_d = ST_PEND;
      ST_PEND: begin
        // commit wins over a same-cycle cancel
        if (commit_i)      state_d = cancel_i ? ST_LATE : ST_COMM;
        else if (cancel_i) state_d = ST_IDLE;
      end
      ST_COMM: begin
        if (ret_i)         state_d = ST_IDLE;
        else if (cancel_i) state_d = ST_LATE;
      end
      ST_LATE: if (ret_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
  end

  p_idle_enq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && enq_i) |=> state_o == ST_PEND);

  p_cancel_pend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PEND && cancel_i && !commit_i) |=> state_o == ST_IDLE);

  p_late_cancel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_COMM && cancel_i && !ret_i) |=> state_o == ST_LATE);

  p_commit_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PEND && commit_i && cancel_i) |=> state_o == ST_LATE);

  p_idle_cancel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && cancel_i && !enq_i) |=> state_o == ST_IDLE);

  p_pend_ret_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PEND && ret_i && !commit_i && !cancel_i) |=> state_o == ST_PEND);
endmodule

// File: rtl/spec_rd_tracker.sv
module spec_rd_tracker
  import srt_pkg::*;
#(
  parameter int NUM_TAGS = 32,
  parameter int RSN_W    = 2,
  localparam int TAG_W   = $clog2(NUM_TAGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enq_valid_i,
  input  logic [TAG_W-1:0] enq_tag_i,
  input  logic             enq_range_hit_i,
  input  logic             commit_valid_i,
  input  logic [TAG_W-1:0] commit_tag_i,
  input  logic             cancel_valid_i,
  input  logic [TAG_W-1:0] cancel_tag_i,
  input  logic [RSN_W-1:0] cancel_reason_i,
  input  logic             ret_valid_i,
  input  logic [TAG_W-1:0] ret_tag_i,
  output logic             drop_o,
  output logic [TAG_W-1:0] drop_tag_o,
  output logic [RSN_W-1:0] drop_reason_o,
  output logic             miss_drop_o,
  output logic [TAG_W-1:0] miss_tag_o,
  output logic             deliver_o,
  output logic             discard_o,
  output logic [TAG_W-1:0] ret_tag_o,
  output logic             err_o
);
  logic [NUM_TAGS-1:0] enq_hot, commit_hot, cancel_hot, ret_hot;
  tag_state_e          tag_st [NUM_TAGS];
  tag_state_e          cancel_st, ret_st;
  logic                cancel_with_commit, cancel_with_ret;
  logic                drop_d, deliver_d, discard_d, err_set;

  srt_onehot #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_dec_enq (
    .valid_i(enq_valid_i && enq_range_hit_i), .tag_i(enq_tag_i), .hot_o(enq_hot));
  srt_onehot #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_dec_commit (
    .valid_i(commit_valid_i), .tag_i(commit_tag_i), .hot_o(commit_hot));
  srt_onehot #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_dec_cancel (
    .valid_i(cancel_valid_i), .tag_i(cancel_tag_i), .hot_o(cancel_hot));
  srt_onehot #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_dec_ret (
    .valid_i(ret_valid_i), .tag_i(ret_tag_i), .hot_o(ret_hot));

  for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
    srt_entry u_entry (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .enq_i   (enq_hot[t]),
      .commit_i(commit_hot[t]),
      .cancel_i(cancel_hot[t]),
      .ret_i   (ret_hot[t]),
      .state_o (tag_st[t])
    );
  end

  srt_state_mux #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_mux_cancel (
    .st_i(tag_st), .sel_i(cancel_tag_i), .st_o(cancel_st));
  srt_state_mux #(.N(NUM_TAGS), .TAG_W(TAG_W)) u_mux_ret (
    .st_i(tag_st), .sel_i(ret_tag_i), .st_o(ret_st));

  assign cancel_with_commit = commit_valid_i && (commit_tag_i == cancel_tag_i);
  assign cancel_with_ret    = ret_valid_i && (ret_tag_i == cancel_tag_i);

  always_comb begin
    drop_d    = cancel_valid_i && (cancel_st == ST_PEND) && !cancel_with_commit;
    err_set   = cancel_valid_i && (cancel_st == ST_IDLE);
    deliver_d = 1'b0;
    discard_d = 1'b0;
    if (ret_valid_i) begin
      unique case (ret_st)
        ST_COMM: begin
          // a cancel landing with the return is still a late cancel
          if (cancel_valid_i && cancel_with_ret) discard_d = 1'b1;
          else                                   deliver_d = 1'b1;
        end
        ST_LATE: discard_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drop_o        <= 1'b0;
      drop_tag_o    <= '0;
      drop_reason_o <= '0;
      miss_drop_o   <= 1'b0;
      miss_tag_o    <= '0;
      deliver_o     <= 1'b0;
      discard_o     <= 1'b0;
      ret_tag_o     <= '0;
      err_o         <= 1'b0;
    end else begin
      drop_o      <= drop_d;
      miss_drop_o <= enq_valid_i && !enq_range_hit_i;
      deliver_o   <= deliver_d;
      discard_o   <= discard_d;
      if (drop_d) begin
        drop_tag_o    <= cancel_tag_i;
        drop_reason_o <= cancel_reason_i;
      end
      if (enq_valid_i && !enq_range_hit_i) miss_tag_o <= enq_tag_i;
      if (ret_valid_i) ret_tag_o <= ret_tag_i;
      if (err_set) err_o <= 1'b1;
    end
  end

  p_drop_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> ($past(cancel_valid_i) && drop_tag_o == $past(cancel_tag_i)));

  p_reason_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> drop_reason_o == $past(cancel_reason_i));

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_one_outcome_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(deliver_o && discard_o));

  p_ret_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deliver_o || discard_o) |-> ($past(ret_valid_i) && ret_tag_o == $past(ret_tag_i)));

  p_miss_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_drop_o |-> ($past(enq_valid_i) && !$past(enq_range_hit_i)));
endmodule

// File: tb/tb_spec_rd_tracker.sv
`timescale 1ns/1ps
module tb_spec_rd_tracker;
  localparam int NUM_TAGS = 32;
  localparam int TAG_W    = $clog2(NUM_TAGS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_v = 1'b0, enq_hit = 1'b0, com_v = 1'b0, can_v = 1'b0, ret_v = 1'b0;
  logic [TAG_W-1:0] enq_t = '0, com_t = '0, can_t = '0, ret_t = '0;
  logic [1:0] can_r = '0;
  logic drop, miss, deliver, discard, err;
  logic [TAG_W-1:0] drop_t, miss_t, rtag;
  logic [1:0] drop_r;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spec_rd_tracker #(.NUM_TAGS(NUM_TAGS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .enq_valid_i(enq_v), .enq_tag_i(enq_t), .enq_range_hit_i(enq_hit),
    .commit_valid_i(com_v), .commit_tag_i(com_t),
    .cancel_valid_i(can_v), .cancel_tag_i(can_t), .cancel_reason_i(can_r),
    .ret_valid_i(ret_v), .ret_tag_i(ret_t),
    .drop_o(drop), .drop_tag_o(drop_t), .drop_reason_o(drop_r),
    .miss_drop_o(miss), .miss_tag_o(miss_t),
    .deliver_o(deliver), .discard_o(discard), .ret_tag_o(rtag), .err_o(err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // inputs are set after a falling edge; this captures them and clears them
  task automatic step();
    @(negedge clk);
    enq_v = 1'b0; com_v = 1'b0; can_v = 1'b0; ret_v = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic enq(input int t, input logic hit);
    enq_v = 1'b1; enq_t = TAG_W'(t); enq_hit = hit;
  endtask
  task automatic commit(input int t);
    com_v = 1'b1; com_t = TAG_W'(t);
  endtask
  task automatic cancel(input int t, input int r);
    can_v = 1'b1; can_t = TAG_W'(t); can_r = 2'(r);
  endtask
  task automatic ret(input int t);
    ret_v = 1'b1; ret_t = TAG_W'(t);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "drop in reset", drop, 0);
    check("R1", "deliver|discard in reset", deliver | discard, 0);
    check("R1", "err in reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "miss after reset", miss, 0);
  endtask

  task automatic t_cancel_pending();
    enq(5, 1'b1); step();
    check("R2", "no output on enqueue", {drop, miss, deliver, discard}, 0);
    cancel(5, 2); step();
    check("R3", "drop", drop, 1);
    check("R3", "drop tag", drop_t, 5);
    check("R11", "reason coherency", drop_r, 2);
    ret(5); step();
    check("R10", "return on idle ignored", {deliver, discard}, 0);
    check("R3", "drop one cycle", drop, 0);
    check("R6", "no error yet", err, 0);
  endtask

  task automatic t_reasons();
    for (int r = 0; r < 4; r++) begin
      enq(7, 1'b1); step();
      cancel(7, r); step();
      check("R11", "drop reason", drop_r, r);
      check("R11", "drop tag", drop_t, 7);
    end
  endtask

  task automatic t_commit_deliver();
    enq(9, 1'b1); step();
    commit(9); step();
    check("R4", "no drop on commit", drop, 0);
    ret(9); step();
    check("R7", "deliver", deliver, 1);
    check("R7", "no discard", discard, 0);
    check("R7", "ret tag", rtag, 9);
    ret(9); step();
    check("R7", "tag idle after return", {deliver, discard}, 0);
  endtask

  task automatic t_late_cancel();
    enq(3, 1'b1); step();
    commit(3); step();
    cancel(3, 1); step();
    check("R4", "late cancel no drop", drop, 0);
    check("R4", "late cancel no err", err, 0);
    ret(3); step();
    check("R4", "discard", discard, 1);
    check("R4", "no deliver", deliver, 0);
    check("R4", "ret tag", rtag, 3);
  endtask

  task automatic t_same_cycle_commit_cancel();
    enq(12, 1'b1); step();
    commit(12); cancel(12, 3); step();
    check("R5", "commit wins, no drop", drop, 0);
    ret(12); step();
    check("R5", "discard", discard, 1);
    check("R5", "no deliver", deliver, 0);
  endtask

  task automatic t_ret_with_cancel();
    enq(20, 1'b1); step();
    commit(20); step();
    ret(20); cancel(20, 0); step();
    check("R9", "discard", discard, 1);
    check("R9", "no deliver", deliver, 0);
    check("R9", "no drop", drop, 0);
    ret(20); step();
    check("R9", "tag idle", {deliver, discard}, 0);
  endtask

  task automatic t_pending_return();
    enq(31, 1'b1); step();
    ret(31); step();
    check("R10", "return on pending ignored", {deliver, discard}, 0);
    cancel(31, 1); step();
    check("R10", "still cancellable", drop, 1);
    check("R10", "drop tag", drop_t, 31);
  endtask

  task automatic t_miss_and_error();
    enq(14, 1'b0); step();
    check("R8", "miss drop", miss, 1);
    check("R8", "miss tag", miss_t, 14);
    cancel(14, 1); step();
    check("R8", "missed tag stays idle, no drop", drop, 0);
    check("R6", "err set", err, 1);
    check("R8", "miss one cycle", miss, 0);
    step(); step();
    check("R6", "err sticky", err, 1);
    do_reset();
    check("R1", "err cleared by reset", err, 0);
  endtask

  task automatic t_parallel();
    enq(2, 1'b1); step();
    enq(4, 1'b1); step();
    commit(2); cancel(4, 3); enq(6, 1'b1); step();
    check("R12", "drop tag 4", {drop, drop_t}, {1'b1, TAG_W'(4)});
    check("R12", "drop reason", drop_r, 3);
    ret(2); cancel(6, 0); step();
    check("R12", "deliver tag 2", {deliver, rtag}, {1'b1, TAG_W'(2)});
    check("R12", "drop tag 6", {drop, drop_t}, {1'b1, TAG_W'(6)});
    check("R12", "no error", err, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_cancel_pending();
    t_reasons();
    t_commit_deliver();
    t_late_cancel();
    t_same_cycle_commit_cancel();
    t_ret_with_cancel();
    t_pending_return();
    t_miss_and_error();
    t_parallel();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule